// File: doc/BRIEF.md
# Whole-Cache Maintenance Sequencer

This block runs the two whole-cache maintenance operations of a write-back cache. It takes one command at a time. The first operation is a flush: it writes back every modified line, invalidates the cache and then issues two special bus cycles. The second is a discard: it invalidates the cache without writing anything back, then issues one special bus cycle.

The block works on the tag/state array through a line index. It reads that line's valid and dirty bits combinationally in the same cycle. It can clear the dirty bit of the indexed line, and it can clear every valid bit with a single pulse. Modified lines leave through a request/acknowledge handshake that names the line index. The bus side performs the special cycles through a second request/acknowledge pair that carries a cycle code. A busy flag covers the whole operation.

The scan visits one line per clock, so a flush takes at least one clock for each line in the cache. Every write-back adds the time its handshake takes. Once a command is accepted, only reset can stop it.

Top module: `cmaint_seq`

## Requirements
- R1: During and right after reset, busy, wb_req, spc_req, arr_clr_dirty and arr_inval_all are all low.
- R2: A command is taken when cmd_valid is high while busy is low. cmd_op=1 selects flush (write back, then invalidate) and cmd_op=0 selects discard (invalidate only). busy is high from the cycle after acceptance until the acknowledge of the last special cycle, and it is low after that.
- R3: A flush visits each line index from 0 to SETS*WAYS-1 exactly once, in ascending order. It requests a write-back on wb_req/wb_idx for exactly the lines whose valid and dirty bits are both set, and for no other line.
- R4: wb_req holds with a stable wb_idx until wb_ack. In the cycle of wb_ack, arr_clr_dirty clears the dirty bit of that same line. Lines that are not written back keep their dirty bit.
- R5: After the scan, arr_inval_all pulses for exactly one cycle. After either command, every valid bit is clear.
- R6: In a flush, the busy cycles before the invalidate pulse number exactly SETS*WAYS plus the cycles that wb_req is high. This is never fewer than SETS*WAYS.
- R7: A discard raises no wb_req and changes no dirty bit. Its invalidate pulse comes in the first busy cycle. It then issues one special cycle with code 2'b10 (flush).
- R8: A flush issues exactly two special cycles, first code 2'b01 (write-back complete) and then code 2'b10 (flush). spc_req and spc_code hold until spc_ack.
- R9: A command that arrives while busy is ignored. It neither interrupts nor alters the running operation, and it does not start a new operation afterwards.
- R10: Reset in the middle of an operation stops it. busy drops and no invalidate pulse or special cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 1 = flush with write-back, 0 = discard |
| busy | output | 1 | Operation in progress |
| arr_idx | output | IDXW | Line index presented to the tag/state array |
| arr_valid | input | 1 | Valid bit of the indexed line |
| arr_dirty | input | 1 | Dirty bit of the indexed line |
| arr_clr_dirty | output | 1 | Clear the dirty bit of the indexed line |
| arr_inval_all | output | 1 | Clear every valid bit |
| wb_req | output | 1 | Write-back request |
| wb_idx | output | IDXW | Line index to write back |
| wb_ack | input | 1 | Write-back accepted |
| spc_req | output | 1 | Special bus cycle request |
| spc_code | output | 2 | Special cycle code (01 write-back complete, 10 flush) |
| spc_ack | input | 1 | Special cycle done |

## Verification
The flush is run against four preloaded array patterns:
- An all-clean cache shows that the scan time falls to its one-clock-per-line minimum.
- An all-dirty cache shows that the scan pauses at every line and resumes in order.
- A random mix tests that write-back selection is exact.
- Lines that are dirty but not valid separate a correct valid-and-dirty test from one that looks only at the dirty bit.

Handshake delays are varied so that the cycle count exposes any lost or extra wait states. Discards on dirty contents, commands sent in the middle of a flush, and a reset in the middle of a flush each test one of the remaining rules.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SCAN   = 3'd1,
        ST_WBWAIT = 3'd2,
        ST_INVAL  = 3'd3,
        ST_SPC    = 3'd4
    } st_e;

    typedef enum logic {
        OP_DISCARD = 1'b0,
        OP_FLUSH   = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        SPC_NONE   = 2'b00,
        SPC_WBDONE = 2'b01,
        SPC_FLUSH  = 2'b10
    } spc_e;

    // Control strobes from the sequencer to the datapath pieces
    typedef struct packed {
        logic scan_clr;
        logic scan_adv;
        logic clr_dirty;
        logic inval_all;
        logic spc_start;
        logic spc_two;
    } ctl_s;

    function automatic spc_e first_code(input logic two);
        return two ? SPC_WBDONE : SPC_FLUSH;
    endfunction

endpackage

// File: rtl/cmaint_scan.sv
module cmaint_scan #(
    parameter int LINES = 512,
    parameter int IDXW  = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            adv,
    output logic [IDXW-1:0] idx,
    output logic            last
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(LINES - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (adv) begin
            idx <= idx + 1'b1;
        end
    end

    assign last = (idx == LAST_IDX);
endmodule

// File: rtl/cmaint_spc.sv
module cmaint_spc
    import cmaint_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       two,
    input  logic       ack,
    output logic       req,
    output logic [1:0] code,
    output logic       done
);
    logic active;
    logic pend2;
    spc_e code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pend2  <= 1'b0;
            code_q <= SPC_NONE;
        end else if (start) begin
            active <= 1'b1;
            pend2  <= two;
            code_q <= first_code(two);
        end else if (active && ack) begin
            if (pend2) begin
                pend2  <= 1'b0;
                code_q <= SPC_FLUSH;
            end else begin
                active <= 1'b0;
                code_q <= SPC_NONE;
            end
        end
    end

    assign req  = active;
    assign code = code_q;
    assign done = active && ack && !pend2;
endmodule

// File: rtl/cmaint_ctrl.sv
module cmaint_ctrl
    import cmaint_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    input  logic cmd_op,
    input  logic line_valid,
    input  logic line_dirty,
    input  logic last,
    input  logic wb_ack,
    input  logic spc_done,
    output ctl_s ctl,
    output logic wb_req,
    output logic busy
);
    st_e st, st_nxt;
    op_e op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            op_q <= OP_DISCARD;
        end else begin
            st <= st_nxt;
            if (st == ST_IDLE && cmd_valid) begin
                op_q <= op_e'(cmd_op);
            end
        end
    end

    always_comb begin
        ctl    = '0;
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    ctl.scan_clr = 1'b1;
                    st_nxt = (op_e'(cmd_op) == OP_FLUSH) ? ST_SCAN : ST_INVAL;
                end
            end
            ST_SCAN: begin
                if (line_valid && line_dirty) begin
                    st_nxt = ST_WBWAIT;
                end else if (last) begin
                    st_nxt = ST_INVAL;
                end else begin
                    ctl.scan_adv = 1'b1;
                end
            end
            ST_WBWAIT: begin
                if (wb_ack) begin
                    ctl.clr_dirty = 1'b1;
                    if (last) begin
                        st_nxt = ST_INVAL;
                    end else begin
                        ctl.scan_adv = 1'b1;
                        st_nxt = ST_SCAN;
                    end
                end
            end
            ST_INVAL: begin
                ctl.inval_all = 1'b1;
                ctl.spc_start = 1'b1;
                ctl.spc_two   = (op_q == OP_FLUSH);
                st_nxt = ST_SPC;
            end
            ST_SPC: begin
                if (spc_done) begin
                    st_nxt = ST_IDLE;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign wb_req = (st == ST_WBWAIT);
    assign busy   = (st != ST_IDLE);
endmodule

// File: rtl/cmaint_seq.sv
module cmaint_seq
    import cmaint_pkg::*;
#(
    parameter  int SETS  = 128,
    parameter  int WAYS  = 4,
    localparam int LINES = SETS * WAYS,
    localparam int IDXW  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic            cmd_op,
    output logic            busy,
    output logic [IDXW-1:0] arr_idx,
    input  logic            arr_valid,
    input  logic            arr_dirty,
    output logic            arr_clr_dirty,
    output logic            arr_inval_all,
    output logic            wb_req,
    output logic [IDXW-1:0] wb_idx,
    input  logic            wb_ack,
    output logic            spc_req,
    output logic [1:0]      spc_code,
    input  logic            spc_ack
);
    ctl_s            ctl;
    logic [IDXW-1:0] idx;
    logic            last;
    logic            spc_done;

    cmaint_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .line_valid (arr_valid),
        .line_dirty (arr_dirty),
        .last       (last),
        .wb_ack     (wb_ack),
        .spc_done   (spc_done),
        .ctl        (ctl),
        .wb_req     (wb_req),
        .busy       (busy)
    );

    cmaint_scan #(.LINES(LINES), .IDXW(IDXW)) u_scan (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctl.scan_clr),
        .adv  (ctl.scan_adv),
        .idx  (idx),
        .last (last)
    );

    cmaint_spc u_spc (
        .clk   (clk),
        .rst   (rst),
        .start (ctl.spc_start),
        .two   (ctl.spc_two),
        .ack   (spc_ack),
        .req   (spc_req),
        .code  (spc_code),
        .done  (spc_done)
    );

    assign arr_idx       = idx;
    assign wb_idx        = idx;
    assign arr_clr_dirty = ctl.clr_dirty;
    assign arr_inval_all = ctl.inval_all;
endmodule

// File: rtl/cmaint_seq_chk.sv
module cmaint_seq_chk #(
    parameter int LINES = 512,
    parameter int IDXW  = 9
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic            cmd_op,
    input logic            busy,
    input logic [IDXW-1:0] arr_idx,
    input logic            arr_clr_dirty,
    input logic            arr_inval_all,
    input logic            wb_req,
    input logic [IDXW-1:0] wb_idx,
    input logic            wb_ack,
    input logic            spc_req,
    input logic [1:0]      spc_code,
    input logic            spc_ack
);
    logic            op_wb;
    int unsigned     cyc;
    logic            prev_ok;
    logic [IDXW-1:0] prev_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_wb    <= 1'b0;
            cyc      <= 0;
            prev_ok  <= 1'b0;
            prev_idx <= '0;
        end else begin
            if (cmd_valid && !busy) begin
                op_wb <= cmd_op;
                cyc   <= 0;
            end else if (busy) begin
                cyc <= cyc + 1;
            end
            if (!busy) begin
                prev_ok <= 1'b0;
            end else if (wb_req && wb_ack) begin
                prev_ok  <= 1'b1;
                prev_idx <= wb_idx;
            end
        end
    end

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!wb_req && !spc_req && !arr_inval_all && !arr_clr_dirty));

    p_busy_end_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(spc_req && spc_ack));

    p_ascend_r3: assert property (@(posedge clk) disable iff (rst)
        (wb_req && prev_ok) |-> (wb_idx > prev_idx));

    p_wb_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_idx)));

    p_clr_on_ack_r4: assert property (@(posedge clk) disable iff (rst)
        arr_clr_dirty |-> (wb_req && wb_ack && arr_idx == wb_idx));

    p_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wb_req, spc_req, arr_inval_all}));

    p_min_scan_r6: assert property (@(posedge clk) disable iff (rst)
        (arr_inval_all && op_wb) |-> (cyc >= LINES));

    p_discard_nowb_r7: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> op_wb);

    p_spc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (spc_req && !spc_ack) |=> (spc_req && $stable(spc_code)));

    p_spc_code_r8: assert property (@(posedge clk) disable iff (rst)
        spc_req |-> (spc_code == 2'b01 || spc_code == 2'b10));
endmodule

bind cmaint_seq cmaint_seq_chk #(.LINES(LINES), .IDXW(IDXW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .busy          (busy),
    .arr_idx       (arr_idx),
    .arr_clr_dirty (arr_clr_dirty),
    .arr_inval_all (arr_inval_all),
    .wb_req        (wb_req),
    .wb_idx        (wb_idx),
    .wb_ack        (wb_ack),
    .spc_req       (spc_req),
    .spc_code      (spc_code),
    .spc_ack       (spc_ack)
);

// File: tb/cmaint_seq_bench.sv
module cmaint_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETS  = 16;
    localparam int WAYS  = 4;
    localparam int LINES = SETS * WAYS;
    localparam int IDXW  = $clog2(LINES);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cmd_valid = 1'b0;
    logic            cmd_op = 1'b0;
    logic            busy;
    logic [IDXW-1:0] arr_idx;
    logic            arr_valid, arr_dirty;
    logic            arr_clr_dirty, arr_inval_all;
    logic            wb_req;
    logic [IDXW-1:0] wb_idx;
    logic            wb_ack = 1'b0;
    logic            spc_req;
    logic [1:0]      spc_code;
    logic            spc_ack = 1'b0;

    // tag/state array model
    logic v [LINES];
    logic d [LINES];
    logic v0 [LINES];
    logic d0 [LINES];

    // monitor state
    int wb_dly = 0, spc_dly = 0;
    int wb_cnt = 0, spc_cnt = 0;
    int wb_log [LINES];
    int wb_n = 0;
    int spc_log [4];
    int spc_n = 0;
    int inval_n = 0;
    int scan_cyc = 0;
    bit seen_inval = 0;
    int n_chk = 0, n_fail = 0;

    cmaint_seq #(.SETS(SETS), .WAYS(WAYS)) u_cmaint_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .busy(busy),
        .arr_idx(arr_idx), .arr_valid(arr_valid), .arr_dirty(arr_dirty),
        .arr_clr_dirty(arr_clr_dirty), .arr_inval_all(arr_inval_all),
        .wb_req(wb_req), .wb_idx(wb_idx), .wb_ack(wb_ack),
        .spc_req(spc_req), .spc_code(spc_code), .spc_ack(spc_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign arr_valid = v[arr_idx];
    assign arr_dirty = d[arr_idx];

    // Responders, monitors and array updates, all away from the rising edge
    initial begin
        logic p_clr, p_inv;
        int   p_idx;
        forever begin
            @(negedge clk);
            if (rst) begin
                wb_ack = 0; spc_ack = 0; wb_cnt = 0; spc_cnt = 0;
            end else begin
                if (busy && !seen_inval && !arr_inval_all) scan_cyc++;
                if (arr_inval_all) begin inval_n++; seen_inval = 1; end
                if (wb_ack) wb_ack = 0;
                else if (wb_req) begin
                    if (wb_cnt >= wb_dly) begin
                        wb_ack = 1; wb_cnt = 0;
                        if (wb_n < LINES) wb_log[wb_n] = int'(wb_idx);
                        wb_n++;
                    end else wb_cnt++;
                end
                if (spc_ack) spc_ack = 0;
                else if (spc_req) begin
                    if (spc_cnt >= spc_dly) begin
                        spc_ack = 1; spc_cnt = 0;
                        if (spc_n < 4) spc_log[spc_n] = int'(spc_code);
                        spc_n++;
                    end else spc_cnt++;
                end
            end
            #(CLK_PERIOD/4);
            p_clr = arr_clr_dirty && !rst;
            p_inv = arr_inval_all && !rst;
            p_idx = int'(arr_idx);
            @(posedge clk);
            #1;
            if (p_clr) d[p_idx] = 0;
            if (p_inv) for (int i = 0; i < LINES; i++) v[i] = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // mode 0 all clean, 1 all dirty, 2 random, 3 dirty-but-invalid mix
    task automatic preload(input int mode);
        for (int i = 0; i < LINES; i++) begin
            case (mode)
                0: begin v[i] = 1; d[i] = 0; end
                1: begin v[i] = 1; d[i] = 1; end
                2: begin v[i] = 1'($urandom_range(0, 1)); d[i] = 1'($urandom_range(0, 1)); end
                default: begin v[i] = (i % 3) != 0; d[i] = (i % 2) == 0; end
            endcase
            v0[i] = v[i]; d0[i] = d[i];
        end
    endtask

    task automatic clear_mon();
        wb_n = 0; spc_n = 0; inval_n = 0; scan_cyc = 0; seen_inval = 0;
    endtask

    task automatic issue(input bit op);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 0;
        check(busy == 1, "R2 busy after accept", int'(busy), 1);
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 8000) begin @(negedge clk); k++; end
        check(!busy, "R2 operation completes", int'(busy), 0);
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic check_flush_result(input string nm);
        int exp_n = 0;
        bit list_ok = 1;
        bit vclr = 1;
        bit dok = 1;
        for (int i = 0; i < LINES; i++) begin
            if (v0[i] && d0[i]) begin
                if (exp_n >= wb_n || exp_n >= LINES || wb_log[exp_n] != i) list_ok = 0;
                exp_n++;
            end
            if (v[i]) vclr = 0;
            if (d[i] != ((v0[i] && d0[i]) ? 1'b0 : d0[i])) dok = 0;
        end
        check(wb_n == exp_n, {"R3 write-back count ", nm}, wb_n, exp_n);
        check(list_ok, {"R3 write-back addresses ascending and exact ", nm}, int'(list_ok), 1);
        check(dok, {"R4 dirty bits after flush ", nm}, int'(dok), 1);
        check(vclr && inval_n == 1, {"R5 valid cleared by one pulse ", nm}, inval_n, 1);
        check(scan_cyc == LINES + exp_n * (wb_dly + 1), {"R6 scan cycles ", nm},
              scan_cyc, LINES + exp_n * (wb_dly + 1));
        check(scan_cyc >= LINES, {"R6 scan minimum ", nm}, scan_cyc, LINES);
        check(spc_n == 2, {"R8 special cycle count ", nm}, spc_n, 2);
        if (spc_n == 2) begin
            check(spc_log[0] == 1, {"R8 first code ", nm}, spc_log[0], 1);
            check(spc_log[1] == 2, {"R8 second code ", nm}, spc_log[1], 2);
        end
    endtask

    task automatic t_reset();
        check(!busy && !wb_req && !spc_req && !arr_clr_dirty && !arr_inval_all,
              "R1 outputs quiet in reset", int'(busy), 0);
        @(negedge clk); rst = 0;
        @(negedge clk);
        check(!busy && !wb_req && !spc_req && !arr_inval_all,
              "R1 outputs quiet after reset", int'(busy), 0);
    endtask

    task automatic t_flush(input int mode, input int wd, input int sd, input string nm);
        preload(mode);
        wb_dly = wd; spc_dly = sd;
        clear_mon();
        issue(1'b1);
        wait_idle();
        check_flush_result(nm);
    endtask

    task automatic t_discard();
        bit dsame = 1;
        bit vclr = 1;
        preload(2);
        spc_dly = 2;
        clear_mon();
        issue(1'b0);
        wait_idle();
        for (int i = 0; i < LINES; i++) begin
            if (d[i] != d0[i]) dsame = 0;
            if (v[i]) vclr = 0;
        end
        check(wb_n == 0, "R7 discard no write-back", wb_n, 0);
        check(dsame, "R7 discard keeps dirty bits", int'(dsame), 1);
        check(scan_cyc == 0, "R7 invalidate in first busy cycle", scan_cyc, 0);
        check(vclr && inval_n == 1, "R5 discard clears valid", inval_n, 1);
        check(spc_n == 1, "R7 one special cycle", spc_n, 1);
        if (spc_n == 1) check(spc_log[0] == 2, "R7 flush code", spc_log[0], 2);
    endtask

    task automatic t_busy_ignore();
        preload(2);
        wb_dly = 1; spc_dly = 1;
        clear_mon();
        issue(1'b1);
        for (int k = 0; k < 3; k++) begin
            repeat (5) @(negedge clk);
            cmd_valid = 1; cmd_op = 1'b0;
            @(negedge clk);
            cmd_valid = 0;
        end
        wait_idle();
        check_flush_result("R9 commands while busy");
        repeat (10) @(negedge clk);
        check(!busy && spc_n == 2, "R9 no restart after ignored commands", spc_n, 2);
    endtask

    task automatic t_reset_abort();
        preload(1);
        wb_dly = 3; spc_dly = 0;
        clear_mon();
        issue(1'b1);
        repeat (15) @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !wb_req && !spc_req, "R10 reset stops operation", int'(busy), 0);
        repeat (20) @(negedge clk);
        check(inval_n == 0 && spc_n == 0 && !busy, "R10 nothing follows reset",
              inval_n + spc_n, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin v[i] = 0; d[i] = 0; end
        repeat (3) @(negedge clk);
        t_reset();
        t_flush(0, 0, 0, "all clean");
        t_flush(1, 0, 1, "all dirty");
        t_flush(2, 2, 0, "random");
        t_flush(3, 1, 3, "dirty but invalid");
        t_discard();
        t_busy_ignore();
        t_reset_abort();
        t_flush(2, 0, 0, "after abort");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule